// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column addresses for one memory burst on a synchronous DRAM. A single-cycle start pulse captures the first column, a burst length code, the ordering type and whether the access is a write. From the next clock on, the block presents one column per clock with a valid flag. It raises a last flag on the final beat of a fixed-length burst.

Two orderings are supported. In sequential order the column counts upward but wraps inside the aligned block of the burst length. In interleaved order the low column bits are XORed with the beat index. A full-page burst walks the whole column space, wrapping from the top column back to zero, and runs until a terminate input ends it. A single-write mode makes every write a one-beat burst while reads keep the programmed length. A start that arrives during a burst abandons the running burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `valid_o` and `last_o` are 0.
- R2: A start sampled at a rising edge makes `valid_o` 1 from that edge on, with `col_o` equal to the captured start column as beat 0. Each further rising edge advances one beat.
- R3: Length codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. In sequential order, beat i carries the start column with its low log2(length) bits replaced by (start + i) modulo the length. The upper bits are unchanged.
- R4: With `ilv_i` = 1 and length code 2 or 3, beat i carries the start column with its low log2(length) bits XORed with i.
- R5: `last_o` is 1 exactly on beat length−1 of a fixed-length burst. `valid_o` falls after that beat unless a new start is sampled. A one-beat burst flags last on beat 0.
- R6: Length code 7 selects a full-page burst. Its column advances by one each beat across all 512 columns, wrapping from 511 to 0. `last_o` stays 0, and the burst continues until it is stopped or restarted.
- R7: `stop_i` sampled during a burst ends it, so `valid_o` is 0 in the following cycle. `stop_i` has no effect while idle.
- R8: `ilv_i` = 1 together with length code 0, 1 or 7 is unsupported and produces sequential order.
- R9: With `wr_single_i` = 1, a burst started with `wr_i` = 1 has one beat. A read started in the same mode keeps the programmed length. With `wr_single_i` = 0, writes also use the programmed length.
- R10: A start sampled during an active burst replaces it. The next cycle shows beat 0 of the new burst, with no gap.
- R11: Reserved length codes 4, 5 and 6 produce a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst; captures the configuration inputs |
| col_i | input | 9 | First column of the burst |
| bl_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| ilv_i | input | 1 | Request interleaved ordering |
| wr_i | input | 1 | The burst is a write |
| wr_single_i | input | 1 | Force write bursts to one beat |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column of the current beat (0 when idle) |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one |

## Verification
The assertions treat `start_i` and `stop_i` as clean single-cycle pulses. They treat the configuration inputs as meaningful only in the cycle a start is sampled, and they never require a stop to win over a start in the same cycle. The bench drives every input on the falling edge and holds start and stop high for exactly one clock. It changes configuration only alongside a start, and it never raises stop and start together. The restart case deliberately overlaps a new start with a running burst, to exercise the replacement path under the same pulse discipline.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [2:0] {
      BLC_ONE  = 3'd0,
      BLC_TWO  = 3'd1,
      BLC_FOUR = 3'd2,
      BLC_EIGHT = 3'd3,
      BLC_PAGE = 3'd7
   } bl_code_e;

   typedef struct packed {
      logic page;
      logic xor_order;
   } burst_mode_t;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
   parameter int COL_W   = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic [2:0]       code_i,
   input  logic             ilv_req_i,
   input  logic             wr_i,
   input  logic             wr_single_i,
   output logic [COL_W-1:0] mask_o,
   output bcs_pkg::burst_mode_t mode_o
);
   import bcs_pkg::*;

   logic [COL_W-1:0] mask_raw;
   logic             page_raw;
   logic             force_one;
   logic             ilv_legal;

   assign force_one = wr_i & wr_single_i;

   always_comb begin
      mask_raw = '0;
      page_raw = 1'b0;
      unique case (code_i)
         BLC_TWO:   mask_raw = COL_W'(1);
         BLC_FOUR:  mask_raw = COL_W'(3);
         BLC_EIGHT: mask_raw = COL_W'(7);
         BLC_PAGE: begin
            mask_raw = '1;
            page_raw = 1'b1;
         end
         default:   mask_raw = '0;
      endcase
   end

   assign ilv_legal = (code_i == BLC_FOUR) || (code_i == BLC_EIGHT);

   generate
      if (HAS_ILV) begin : g_ilv
         assign mode_o.xor_order = ilv_req_i & ilv_legal & ~force_one;
      end else begin : g_no_ilv
         assign mode_o.xor_order = 1'b0;
      end
   endgenerate

   assign mask_o      = force_one ? '0 : mask_raw;
   assign mode_o.page = page_raw & ~force_one;
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [COL_W-1:0] mask_i,
   input  bcs_pkg::burst_mode_t mode_i,
   output logic             active_o,
   output logic             last_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic             xor_o
);
   logic                 active_q;
   logic [COL_W-1:0]     cnt_q;
   logic [COL_W-1:0]     base_q;
   logic [COL_W-1:0]     mask_q;
   bcs_pkg::burst_mode_t mode_q;
   logic                 final_beat;

   assign final_beat = active_q & ~mode_q.page & (cnt_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         base_q   <= '0;
         mask_q   <= '0;
         mode_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         base_q   <= col_i;
         mask_q   <= mask_i;
         mode_q   <= mode_i;
      end else if (active_q) begin
         if (stop_i || final_beat) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + COL_W'(1);
         end
      end
   end

   assign active_o = active_q;
   assign last_o   = final_beat;
   assign cnt_o    = cnt_q;
   assign base_o   = base_q;
   assign mask_o   = mask_q;
   assign xor_o    = mode_q.xor_order;
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
   parameter int COL_W   = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             xor_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] low_sel;

   assign seq_low = base_i + cnt_i;

   generate
      if (HAS_ILV) begin : g_ilv
         logic [COL_W-1:0] xor_low;
         assign xor_low = base_i ^ cnt_i;
         assign low_sel = xor_i ? xor_low : seq_low;
      end else begin : g_seq_only
         assign low_sel = seq_low;
      end
   endgenerate

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_bit
         assign col_o[b] = mask_i[b] ? low_sel[b] : base_i[b];
      end
   endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
   parameter int COL_W   = 9,
   parameter bit HAS_ILV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [2:0]       bl_code_i,
   input  logic             ilv_i,
   input  logic             wr_i,
   input  logic             wr_single_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam int MAX_FIXED_BEATS = 8;
   localparam int MIN_COL_W       = $clog2(MAX_FIXED_BEATS);

   generate
      if (COL_W < MIN_COL_W) begin : g_bad_width
         $error("burst_col_seq: COL_W too small for eight-beat bursts");
      end
   endgenerate

   logic [COL_W-1:0]     dec_mask;
   bcs_pkg::burst_mode_t dec_mode;
   logic                 act;
   logic                 fin;
   logic [COL_W-1:0]     cnt;
   logic [COL_W-1:0]     base;
   logic [COL_W-1:0]     mask;
   logic                 use_xor;
   logic [COL_W-1:0]     gen_col;

   bcs_len_decode #(.COL_W(COL_W), .HAS_ILV(HAS_ILV)) u_dec (
      .code_i      (bl_code_i),
      .ilv_req_i   (ilv_i),
      .wr_i        (wr_i),
      .wr_single_i (wr_single_i),
      .mask_o      (dec_mask),
      .mode_o      (dec_mode)
   );

   bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .col_i    (col_i),
      .mask_i   (dec_mask),
      .mode_i   (dec_mode),
      .active_o (act),
      .last_o   (fin),
      .cnt_o    (cnt),
      .base_o   (base),
      .mask_o   (mask),
      .xor_o    (use_xor)
   );

   bcs_addr_gen #(.COL_W(COL_W), .HAS_ILV(HAS_ILV)) u_gen (
      .base_i (base),
      .cnt_i  (cnt),
      .mask_i (mask),
      .xor_i  (use_xor),
      .col_o  (gen_col)
   );

   assign col_o   = act ? gen_col : '0;
   assign valid_o = act;
   assign last_o  = fin;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] col_i,
   input logic [2:0]       bl_code_i,
   input logic             wr_i,
   input logic             wr_single_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);
   p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o);

   p_start_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (col_o == $past(col_i)));

   p_last_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && last_o && !start_i) |=> !valid_o);

   p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && stop_i && !start_i) |=> !valid_o);

   p_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i) |=> valid_o);

   p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && bl_code_i == 3'd7 && !(wr_i && wr_single_i)) |=> !last_o);

   p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && wr_i && wr_single_i) |=> last_o);

   p_reserved_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && bl_code_i >= 3'd4 && bl_code_i <= 3'd6) |=> last_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .col_i       (col_i),
   .bl_code_i   (bl_code_i),
   .wr_i        (wr_i),
   .wr_single_i (wr_single_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [8:0] col_i = '0;
   logic [2:0] bl_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       wr_i = 1'b0;
   logic       wr_single_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [8:0] col_o;
   logic       valid_o;
   logic       last_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   burst_col_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
      .bl_code_i(bl_code_i), .ilv_i(ilv_i), .wr_i(wr_i),
      .wr_single_i(wr_single_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   function automatic int exp_col(input int base, input int i, input int len, input bit il);
      int m = len - 1;
      int low = il ? ((base ^ i) & m) : ((base + i) & m);
      return (base & ~m & 511) | low;
   endfunction

   // Start a burst, follow nb beats, optionally stop on the last followed beat.
   task automatic burst(input string req, input int c, input int code, input bit il,
                        input bit w, input bit ws, input int nb, input int len,
                        input bit exp_il, input int last_idx, input bit use_stop);
      @(negedge clk);
      start_i = 1'b1; col_i = 9'(c); bl_code_i = 3'(code);
      ilv_i = il; wr_i = w; wr_single_i = ws;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < nb; i++) begin
         chk(req, $sformatf("valid beat %0d", i), int'(valid_o), 1);
         chk(req, $sformatf("col beat %0d", i), int'(col_o), exp_col(c, i, len, exp_il));
         chk(req, $sformatf("last beat %0d", i), int'(last_o), (i == last_idx) ? 1 : 0);
         if (use_stop && i == nb - 1) stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
      end
      chk(req, "valid after burst", int'(valid_o), 0);
      chk(req, "last after burst", int'(last_o), 0);
   endtask

   task automatic t_reset;
      chk("R1", "valid in reset", int'(valid_o), 0);
      chk("R1", "last in reset", int'(last_o), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1", "valid after reset", int'(valid_o), 0);
      chk("R1", "last after reset", int'(last_o), 0);
   endtask

   task automatic t_stop_idle;
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      chk("R7", "valid after idle stop", int'(valid_o), 0);
      @(negedge clk);
      chk("R7", "valid idle later", int'(valid_o), 0);
   endtask

   task automatic t_restart;
      @(negedge clk);
      start_i = 1'b1; col_i = 9'h010; bl_code_i = 3'd3; ilv_i = 1'b0; wr_i = 1'b0; wr_single_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R10", $sformatf("first burst col %0d", i), int'(col_o), 16 + i);
         if (i == 2) begin
            start_i = 1'b1; col_i = 9'h041; bl_code_i = 3'd2; ilv_i = 1'b1;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R10", $sformatf("new valid %0d", i), int'(valid_o), 1);
         chk("R10", $sformatf("new col %0d", i), int'(col_o), exp_col(9'h041, i, 4, 1'b1));
         chk("R10", $sformatf("new last %0d", i), int'(last_o), (i == 3) ? 1 : 0);
         @(negedge clk);
      end
      chk("R10", "idle after new burst", int'(valid_o), 0);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      t_reset();
      burst("R2 R5", 9'h005, 0, 0, 0, 0, 1, 1, 0, 0, 0);
      burst("R3", 9'h003, 1, 0, 0, 0, 2, 2, 0, 1, 0);
      burst("R3", 9'h1A6, 2, 0, 0, 0, 4, 4, 0, 3, 0);
      burst("R3", 9'h0FD, 3, 0, 0, 0, 8, 8, 0, 7, 0);
      burst("R4", 9'h1A5, 2, 1, 0, 0, 4, 4, 1, 3, 0);
      burst("R4", 9'h0F3, 3, 1, 0, 0, 8, 8, 1, 7, 0);
      burst("R6 R8", 9'h1FE, 7, 1, 0, 0, 6, 512, 0, -1, 1);
      burst("R8", 9'h002, 1, 1, 0, 0, 2, 2, 0, 1, 0);
      burst("R7", 9'h022, 3, 0, 0, 0, 3, 8, 0, -1, 1);
      t_stop_idle();
      burst("R9", 9'h033, 3, 0, 1, 1, 1, 1, 0, 0, 0);
      burst("R9", 9'h035, 2, 0, 0, 1, 4, 4, 0, 3, 0);
      burst("R9", 9'h036, 2, 0, 1, 0, 4, 4, 0, 3, 0);
      burst("R11", 9'h077, 5, 0, 0, 0, 1, 1, 0, 0, 0);
      t_restart();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule